// File: doc/BRIEF.md
# Next-PC Redirect Target Unit

This block sits in the execute stage of a pipelined processor and works out where the fetch stage should go next. From the current program counter, a sign-extended immediate, the ALU result and two decode flags (an indirect jump through a register, and a conditional branch), it produces three candidate addresses and one select bit. The candidates are the next sequential address, the PC-relative sum with the immediate unscaled, and the redirect target.

The redirect target has two sources. For an indirect jump it is the ALU result with its lowest bit cleared. Otherwise it is the current PC plus the immediate shifted left by one place. The select bit asks the fetch stage to take the redirect target. It is set for every indirect jump, and for a conditional branch whose comparison result (delivered in bit 0 of the ALU result) is one. The unit is purely combinational, with no clock, reset or internal state. It has no states or transitions to name.

Top module: `npc_redirect_unit`

## Requirements
- R1: `next_seq_pc` equals `cur_pc + 4`, wrapping modulo 2^32 (0xFFFFFFFC gives 0x00000000).
- R2: `pc_rel` equals `cur_pc + imm_sx` with no scaling, where `imm_sx` is two's complement and the sum wraps modulo 2^32.
- R3: While `is_jalr` is 1, `redirect_tgt` equals `alu_res` with bit 0 forced to 0 and bits 31..1 unchanged.
- R4: While `is_jalr` is 0, `redirect_tgt` equals `cur_pc + (imm_sx << 1)`, wrapping modulo 2^32, with the bits shifted out above bit 31 dropped.
- R5: `redirect_take` equals `is_jalr | (is_branch & alu_res[0])`.
- R6: While `is_jalr` is 1, `redirect_take` is 1 whatever the values of `is_branch` and `alu_res`.
- R7: While `is_jalr` and `is_branch` are both 0, `redirect_take` is 0 whatever `alu_res[0]` is. Bits 31..1 of `alu_res` never affect `redirect_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_pc | input | 32 | Address of the instruction in execute |
| imm_sx | input | 32 | Sign-extended immediate, two's complement |
| is_jalr | input | 1 | Instruction is an indirect jump through a register |
| is_branch | input | 1 | Instruction is a conditional branch |
| alu_res | input | 32 | ALU result; bit 0 carries the branch comparison outcome |
| next_seq_pc | output | 32 | Sequential successor address |
| pc_rel | output | 32 | PC plus unscaled immediate |
| redirect_tgt | output | 32 | Address to fetch from when redirecting |
| redirect_take | output | 1 | Fetch should take `redirect_tgt` |

## Verification
Directed vectors place the PC at the top of the address space and use both the most negative and the most positive immediates. These separate a correct 32-bit wrap from a sign or carry error, and show whether the doubled immediate is applied to the target while the relative sum stays unscaled. All four flag combinations are tried with ALU results of odd and even value and with high bits set. This shows that an indirect jump always redirects with bit 0 cleared, that only bit 0 gates a branch, and that flags off never redirect. A long run of pseudo-random vectors against a behavioural model then covers the arithmetic paths generally.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned SEQ_STEP  = 4;
    localparam int unsigned TGT_SHIFT = 1;

    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/npc_wrap_adder.sv
module npc_wrap_adder #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum
);
    // carry out is dropped: modulo 2^W addition
    always_comb begin
        sum = op_a + op_b;
    end
endmodule

// File: rtl/npc_target_mux.sv
module npc_target_mux #(
    parameter int unsigned W = 32
) (
    input  logic         indirect,
    input  logic [W-1:0] reg_based,
    input  logic [W-1:0] pc_based,
    output logic [W-1:0] target
);
    localparam logic [W-1:0] LSB_CLEAR = ~{{(W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (indirect)
            1'b1:    target = reg_based & LSB_CLEAR;
            default: target = pc_based;
        endcase
    end
endmodule

// File: rtl/npc_redirect_unit.sv
module npc_redirect_unit
    import npc_pkg::*;
(
    input  logic [31:0] cur_pc,
    input  logic [31:0] imm_sx,
    input  logic        is_jalr,
    input  logic        is_branch,
    input  logic [31:0] alu_res,
    output logic [31:0] next_seq_pc,
    output logic [31:0] pc_rel,
    output logic [31:0] redirect_tgt,
    output logic        redirect_take
);
    localparam addr_t STEP_C = addr_t'(SEQ_STEP);

    addr_t imm_scaled;
    addr_t pc_scaled_sum;

    assign imm_scaled = imm_sx << TGT_SHIFT;

    npc_wrap_adder #(.W(ADDR_W)) u_seq (
        .op_a(cur_pc), .op_b(STEP_C), .sum(next_seq_pc)
    );

    npc_wrap_adder #(.W(ADDR_W)) u_rel (
        .op_a(cur_pc), .op_b(imm_sx), .sum(pc_rel)
    );

    npc_wrap_adder #(.W(ADDR_W)) u_tgt (
        .op_a(cur_pc), .op_b(imm_scaled), .sum(pc_scaled_sum)
    );

    npc_target_mux #(.W(ADDR_W)) u_mux (
        .indirect (is_jalr),
        .reg_based(alu_res),
        .pc_based (pc_scaled_sum),
        .target   (redirect_tgt)
    );

    always_comb begin
        redirect_take = is_jalr | (is_branch & alu_res[0]);
    end
endmodule

// File: rtl/npc_redirect_chk.sv
module npc_redirect_chk (
    input logic [31:0] cur_pc,
    input logic [31:0] imm_sx,
    input logic        is_jalr,
    input logic        is_branch,
    input logic [31:0] alu_res,
    input logic [31:0] next_seq_pc,
    input logic [31:0] pc_rel,
    input logic [31:0] redirect_tgt,
    input logic        redirect_take
);
    logic [31:0] seq_gap;
    logic [31:0] rel_gap;
    logic [31:0] tgt_minus_rel;

    always_comb begin
        seq_gap       = next_seq_pc - cur_pc;
        rel_gap       = pc_rel - imm_sx;
        tgt_minus_rel = redirect_tgt - pc_rel;
        AST_SEQ_STEP:   assert (seq_gap == 32'd4);                                // R1
        AST_REL_BACK:   assert (rel_gap == cur_pc);                               // R2
        AST_IND_LSB:    assert (!is_jalr || (redirect_tgt[0] == 1'b0 &&
                                 redirect_tgt[31:1] == alu_res[31:1]));          // R3
        AST_DIR_DOUBLE: assert (is_jalr || tgt_minus_rel == imm_sx);             // R4
        AST_IND_TAKE:   assert (!is_jalr || redirect_take);                       // R6
        AST_NO_FLAGS:   assert (is_jalr || is_branch || !redirect_take);         // R7
        AST_BR_BIT0:    assert (is_jalr || !is_branch ||
                                 redirect_take == alu_res[0]);                   // R5
    end
endmodule

bind npc_redirect_unit npc_redirect_chk u_chk (.*);

// File: tb/sim_npc_redirect_unit.sv
`timescale 1ns/1ps
module sim_npc_redirect_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cur_pc = '0, imm_sx = '0, alu_res = '0;
    logic        is_jalr = 1'b0, is_branch = 1'b0;
    logic [31:0] next_seq_pc, pc_rel, redirect_tgt;
    logic        redirect_take;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    npc_redirect_unit u0 (
        .cur_pc(cur_pc), .imm_sx(imm_sx), .is_jalr(is_jalr),
        .is_branch(is_branch), .alu_res(alu_res),
        .next_seq_pc(next_seq_pc), .pc_rel(pc_rel),
        .redirect_tgt(redirect_tgt), .redirect_take(redirect_take)
    );

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Behavioural model on 64-bit integers, compared every clock
    task automatic apply(input logic [31:0] pc, input logic [31:0] imm,
                         input logic j, input logic b, input logic [31:0] alu);
        longint unsigned m, e_seq, e_rel, e_tgt;
        longint s_imm;
        bit e_take;
        @(posedge clk);
        cur_pc = pc; imm_sx = imm; is_jalr = j; is_branch = b; alu_res = alu;
        m      = 64'hFFFF_FFFF;
        s_imm  = longint'($signed(imm));
        e_seq  = (longint'(pc) + 4) & m;
        e_rel  = (longint'(pc) + s_imm) & m;
        if (j) e_tgt = longint'(alu) - (longint'(alu) % 2);
        else   e_tgt = (longint'(pc) + 2 * s_imm) & m;
        e_take = j ? 1'b1 : (b && (alu % 2 == 1));
        @(negedge clk);
        chk32("R1 next_seq_pc", next_seq_pc, e_seq[31:0]);
        chk32("R2 pc_rel", pc_rel, e_rel[31:0]);
        chk32(j ? "R3 redirect_tgt" : "R4 redirect_tgt", redirect_tgt, e_tgt[31:0]);
        if (j)       chk1("R6 redirect_take", redirect_take, e_take);
        else if (!b) chk1("R7 redirect_take", redirect_take, e_take);
        else         chk1("R5 redirect_take", redirect_take, e_take);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // quiet inputs
        @(negedge clk);
        chk32("R1 idle", next_seq_pc, 32'd4);
        chk1("R7 idle", redirect_take, 1'b0);
        // R1 wrap at top of space
        apply(32'hFFFF_FFFC, 32'd0, 0, 0, 32'd0);
        // R2 / R4 negative and extreme immediates
        apply(32'h0000_1000, 32'hFFFF_FFF0, 0, 0, 32'd0);
        apply(32'h0000_0010, 32'h8000_0000, 0, 1, 32'd1);
        apply(32'h1234_5678, 32'h7FFF_FFFF, 0, 1, 32'd0);
        apply(32'hFFFF_FFF0, 32'h0000_0010, 0, 0, 32'hFFFF_FFFF);
        // R3 / R6 indirect jump with odd and even results
        apply(32'h0000_2000, 32'd8, 1, 0, 32'hDEAD_BEEF);
        apply(32'h0000_2000, 32'd8, 1, 1, 32'h0000_0100);
        apply(32'h0, 32'h0, 1, 0, 32'hFFFF_FFFF);
        // R5 branch decided only by bit 0; R7 high bits ignored
        apply(32'h0000_0400, 32'h0000_0020, 0, 1, 32'hFFFF_FFFE);
        apply(32'h0000_0400, 32'h0000_0020, 0, 1, 32'h0000_0001);
        apply(32'h0000_0400, 32'h0000_0020, 0, 0, 32'hFFFF_FFFF);
        apply(32'h0000_0400, 32'h0000_0020, 0, 0, 32'h0000_0001);
        // pseudo-random sweep
        for (int i = 0; i < 400; i++) begin
            apply($urandom, $urandom, 1'($urandom), 1'($urandom), $urandom);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule